// File: doc/BRIEF.md
# Single-Level Wavelet Analysis Filter Bank

This block splits a stream of signed samples into two half-rate coefficient streams: a smooth (approximation) stream from a low-pass FIR and a detail stream from a high-pass FIR. Only the low-pass taps are supplied, as a parameter in signed fixed point with one integer bit. The high-pass taps are formed inside the block by the quadrature-mirror rule: tap n of the high-pass filter equals tap L-1-n of the low-pass filter, negated when n is odd.

Samples enter through a valid/ready handshake and are numbered from zero after reset. Once each pair of samples is complete, the block issues one approximation and one detail coefficient together under a single valid strobe. The approximation for pair n is the low-pass convolution evaluated at even index 2n. The detail is the high-pass convolution evaluated at odd index 2n+1. The sample history starts at zero, so the first outputs behave as if zeros preceded the stream. To get further decomposition levels, feed the approximation stream into another instance.

Top module: `wavelet_split`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `out_valid` is 0 and both coefficient outputs are 0. `in_ready` is 1 from the first clock edge after reset is released.
- R2: A sample is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. The first sample accepted after reset has index 0.
- R3: `out_valid` is 1 for exactly one cycle, starting at the clock edge that accepts an odd-indexed sample. It is 0 after every even-indexed sample, so it pulses once per two accepted samples.
- R4: `out_approx` for pair n equals the rounded value of the sum over j of h[j]·x[2n-j]. The default h is the two-tap Haar pair, h[0]=h[1]=23170, with 15 fraction bits.
- R5: `out_detail` for pair n equals the rounded value of the sum over j of g[j]·x[2n+1-j], where g[j] = (-1)^j·h[L-1-j]. With the Haar default, g[0]=23170 and g[1]=-23170.
- R6: Samples before index 0 count as zero. With Haar taps, the first approximation equals 23170·x[0] after rounding.
- R7: Rounding adds half of one output LSB and then truncates toward minus infinity, so exact ties move toward plus infinity. For example, 5792.5 gives 5793 and -5792.5 gives -5792.
- R8: A result above 32767 is output as 32767, and a result below -32768 is output as -32768 (default 16-bit samples).
- R9: Cycles with `in_valid` at 0 change neither the pair phase nor the sample history. Results are the same as for an uninterrupted stream.
- R10: Between strobes, `out_approx` and `out_detail` keep their last values.
- R11: A reset in the middle of a stream clears the history and the pair phase. The next accepted sample has index 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block can accept a sample |
| in_sample | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Coefficient pair strobe |
| out_approx | output | DATA_W | Low-pass, decimated coefficient |
| out_detail | output | DATA_W | High-pass, decimated coefficient |

## Verification
The bench targets these corner cases:
- Decimation phase. If both branches were sampled at the same index, or if the approximation ignored the previous pair's odd sample, the ramp sequences would give wrong values.
- Zero padding. A history not cleared at start or on reset would leak stale samples into the first pair.
- Exact rounding ties, in both signs. A design that truncates or rounds half away from zero would be off by one on one side.
- Saturation at both extremes. A design that wraps would flip the sign.
- Idle gaps carrying garbage data. A design that shifts on every cycle would corrupt the history.

// File: rtl/wsplit_pkg.sv
package wsplit_pkg;

    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } pair_phase_e;

    function automatic int acc_bits(input int data_w, input int coef_w, input int taps);
        return data_w + coef_w + $clog2(taps);
    endfunction

endpackage

// File: rtl/wsplit_history.sv
module wsplit_history #(
    parameter int DEPTH  = 3,
    parameter int DATA_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          shift_en,
    input  logic [DATA_W-1:0]             din,
    output logic [DEPTH-1:0][DATA_W-1:0]  win_nx
);

    logic [DEPTH-1:0][DATA_W-1:0] win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (shift_en) begin
            win_d = {win_q[DEPTH-2:0], din};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    assign win_nx = win_d;

    AST_NEWEST_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (win_q[0] == $past(din)));                         // R2
    AST_WINDOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(win_q));                                  // R9

endmodule

// File: rtl/wsplit_mac.sv
module wsplit_mac #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int TAPS   = 2
) (
    input  logic [TAPS-1:0][DATA_W-1:0] samp,
    input  logic [TAPS-1:0][COEF_W-1:0] coef,
    output logic [DATA_W-1:0]           result
);

    localparam int ACC_W = wsplit_pkg::acc_bits(DATA_W, COEF_W, TAPS);
    localparam int FRAC  = COEF_W - 1;
    localparam logic signed [ACC_W-1:0] HALF    = ACC_W'(1) << (FRAC - 1);
    localparam logic signed [ACC_W-1:0] OUT_MAX = {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] OUT_MIN = {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

    logic signed [ACC_W-1:0] acc, sx, cx, rnd, shf;

    always_comb begin
        acc = '0;
        for (int j = 0; j < TAPS; j++) begin
            sx  = ACC_W'($signed(samp[j]));
            cx  = ACC_W'($signed(coef[j]));
            acc = acc + sx * cx;
        end
        rnd = acc + HALF;
        shf = rnd >>> FRAC;
        if (shf > OUT_MAX) begin
            result = OUT_MAX[DATA_W-1:0];
        end else if (shf < OUT_MIN) begin
            result = OUT_MIN[DATA_W-1:0];
        end else begin
            result = shf[DATA_W-1:0];
        end
    end

endmodule

// File: rtl/wavelet_split.sv
module wavelet_split #(
    parameter int                       DATA_W  = 16,
    parameter int                       COEF_W  = 16,
    parameter int                       TAPS    = 2,
    parameter logic [TAPS*COEF_W-1:0]   LP_TAPS = {TAPS{COEF_W'(23170)}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_sample,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_approx,
    output logic [DATA_W-1:0] out_detail
);
    import wsplit_pkg::*;

    localparam int HIST = TAPS + 1;
    localparam logic [TAPS-1:0][COEF_W-1:0] LP_ARR = LP_TAPS;

    typedef struct packed {
        pair_phase_e       phase;
        logic              ready;
        logic              ovalid;
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] hi;
    } ctl_t;

    ctl_t st_d, st_q;
    logic accept;
    logic [HIST-1:0][DATA_W-1:0] win_nx;
    logic [TAPS-1:0][COEF_W-1:0] hp_taps;
    logic [DATA_W-1:0] lo_res, hi_res;

    assign accept = in_valid && st_q.ready;

    // Quadrature-mirror derivation of the high-pass taps
    for (genvar n = 0; n < TAPS; n++) begin : g_qmf
        if (n % 2 == 0) begin : g_pos
            assign hp_taps[n] = LP_ARR[TAPS-1-n];
        end else begin : g_neg
            assign hp_taps[n] = -LP_ARR[TAPS-1-n];
        end
    end

    wsplit_history #(.DEPTH(HIST), .DATA_W(DATA_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (accept),
        .din      (in_sample),
        .win_nx   (win_nx)
    );

    // Low branch: window ending at the even sample (slots 1..TAPS)
    wsplit_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .TAPS(TAPS)) u_mac_lo (
        .samp   (win_nx[TAPS:1]),
        .coef   (LP_ARR),
        .result (lo_res)
    );

    // High branch: window ending at the odd sample (slots 0..TAPS-1)
    wsplit_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .TAPS(TAPS)) u_mac_hi (
        .samp   (win_nx[TAPS-1:0]),
        .coef   (hp_taps),
        .result (hi_res)
    );

    always_comb begin
        st_d        = st_q;
        st_d.ready  = 1'b1;
        st_d.ovalid = 1'b0;
        if (accept) begin
            if (st_q.phase == PH_EVEN) begin
                st_d.phase = PH_ODD;
            end else begin
                st_d.phase  = PH_EVEN;
                st_d.ovalid = 1'b1;
                st_d.lo     = lo_res;
                st_d.hi     = hi_res;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_EVEN, ready: 1'b0, ovalid: 1'b0, lo: '0, hi: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready   = st_q.ready;
    assign out_valid  = st_q.ovalid;
    assign out_approx = st_q.lo;
    assign out_detail = st_q.hi;

    AST_STROBE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && in_ready));                     // R3
    AST_STROBE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);                                      // R3
    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_approx) && $stable(out_detail)));   // R10
    AST_IDLE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> $stable(st_q.phase));               // R9

endmodule

// File: tb/wavelet_split_tb.sv
module wavelet_split_tb_top;

    localparam longint A = 23170;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [15:0] in_sample = '0;
    logic out_valid;
    logic [15:0] out_approx, out_detail;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    longint h0 = 0, h1 = 0, h2 = 0;   // bench history: newest first
    bit     odd_next = 0;             // next sample index is odd
    longint last_lo = 0, last_hi = 0;

    always #10 clk = ~clk;   // 50 MHz

    wavelet_split dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sample(in_sample), .out_valid(out_valid),
        .out_approx(out_approx), .out_detail(out_detail)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint rsat(input longint p);
        longint r = (p + 16384) >>> 15;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
            report();
        end
    end

    // Assumes the caller is at a falling edge; returns at the next one.
    task automatic drive(input longint x, input string req);
        in_valid  = 1'b1;
        in_sample = 16'(x);
        @(negedge clk);
        h2 = h1; h1 = h0; h0 = x;
        if (odd_next) begin
            last_lo = rsat(A * h1 + A * h2);
            last_hi = rsat(A * h0 - A * h1);
            chk(out_valid === 1'b1, {req, " R3 strobe"}, out_valid, 1);
            chk($signed(out_approx) == last_lo, {req, " R4 approx"}, $signed(out_approx), last_lo);
            chk($signed(out_detail) == last_hi, {req, " R5 detail"}, $signed(out_detail), last_hi);
        end else begin
            chk(out_valid === 1'b0, {req, " R3 no strobe on even"}, out_valid, 0);
        end
        odd_next = !odd_next;
    endtask

    task automatic idle(input int n);
        in_valid  = 1'b0;
        in_sample = 16'h5A5A;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(out_valid === 1'b0, "R10 idle strobe", out_valid, 0);
            chk($signed(out_approx) == last_lo && $signed(out_detail) == last_hi,
                "R10 outputs held", $signed(out_approx), last_lo);
        end
    endtask

    task automatic do_reset();
        in_valid = 1'b0;
        rst_n    = 1'b0;
        repeat (2) @(negedge clk);
        chk(out_valid === 1'b0 && out_approx == 16'd0 && out_detail == 16'd0,
            "R1 outputs in reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready === 1'b1, "R1 ready after reset", in_ready, 1);
        chk(out_valid === 1'b0 && out_approx == 16'd0, "R1 idle after reset", out_valid, 0);
        h0 = 0; h1 = 0; h2 = 0; odd_next = 0; last_lo = 0; last_hi = 0;
    endtask

    task automatic t_first_pair();   // R6 zero padding
        drive(1000, "R6 first");
        drive(3000, "R6 first");
        chk($signed(out_approx) == rsat(A * 1000), "R6 padded approx", $signed(out_approx), rsat(A * 1000));
    endtask

    task automatic t_ramp();
        for (int i = 0; i < 16; i++) drive(i * 1500 - 9000, "R2 ramp");
        for (int i = 0; i < 8; i++) drive((i % 2 == 0) ? 20000 : -17000, "R4 alternating");
    endtask

    task automatic t_gaps();         // R9
        drive(4000, "R9 gap");
        idle(3);
        drive(-2500, "R9 gap");
        idle(2);
        drive(700, "R9 gap");
        idle(1);
        drive(12000, "R9 gap");
    endtask

    task automatic t_round();        // R7 ties
        drive(0, "R7 setup");
        drive(0, "R7 setup");
        drive(8192, "R7 tie");
        drive(8192, "R7 tie");
        chk($signed(out_approx) == 5793, "R7 positive tie", $signed(out_approx), 5793);
        drive(-16384, "R7 tie");
        drive(-8192, "R7 tie");
        chk($signed(out_approx) == -5792, "R7 negative tie", $signed(out_approx), -5792);
        chk($signed(out_detail) == 5793, "R7 detail tie", $signed(out_detail), 5793);
    endtask

    task automatic t_sat();          // R8
        drive(32767, "R8 sat");
        drive(32767, "R8 sat");
        drive(32767, "R8 sat");
        drive(-32768, "R8 sat");
        chk($signed(out_approx) == 32767, "R8 positive clamp", $signed(out_approx), 32767);
        chk($signed(out_detail) == -32768, "R8 negative clamp", $signed(out_detail), -32768);
        drive(-32768, "R8 sat");
        drive(32767, "R8 sat");
        chk($signed(out_approx) == -32768, "R8 negative approx clamp", $signed(out_approx), -32768);
    endtask

    task automatic t_restart();      // R11
        drive(9000, "R11 pre");
        drive(-9000, "R11 pre");
        drive(15000, "R11 half pair");
        do_reset();
        drive(2000, "R11 restart");
        drive(2000, "R11 restart");
        chk($signed(out_approx) == rsat(A * 2000), "R11 history cleared", $signed(out_approx), rsat(A * 2000));
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        t_first_pair();
        t_ramp();
        t_gaps();
        t_round();
        t_sat();
        t_restart();
        idle(2);
        done = 1;
        report();
    end

endmodule